// File: doc/BRIEF.md
# Power-Supply Fault Supervisor

This block is the protection sequencer of a combined power-factor-correction and flyback controller. It takes already digitised comparator flags: supply turn-on and turn-off thresholds, power-down reset, supply overvoltage, feedback overload, supply below the short-circuit level, line brown-in and brown-out, the external-latch pin below and above its thresholds, chip over-temperature, and a per-cycle auxiliary-winding overvoltage sample. From these it produces one registered gate enable for both power stages and a 3-bit code that names the most recent fault.

Faults are debounced on two time bases, a millisecond tick and a microsecond tick supplied from outside, with every debounce length a parameter. Faults fall into three recovery classes. Auto-recovery faults wait for the next supply turn-on crossing. An overload waits for four supply turn-off crossings before normal start rules apply again. Latched faults hold the gate off until a power-down reset. Over-temperature is the one fault that releases as soon as its flag clears.

Top module: `psu_fault_supervisor`

## Requirements
- R1: After reset, `gate_en` rises on the second clock edge after a rising edge of `uv_on`. It rises only if `brown_in` has been high since the last reset or brown-out trip and `over_temp` is low. With no `brown_in` seen, `gate_en` stays low.
- R2: While switching, `brown_out` held for BNO_MS ms ticks turns the gate off and sets `fault_code` 1. Re-enable then needs `brown_in` to be seen again and a new `uv_on` rising edge.
- R3: After start-up, `fb_overload` held for OLP_RUN_MS ms ticks turns the gate off with `fault_code` 2. The count restarts from zero whenever the flag drops for one cycle.
- R4: From enable until `fb_overload` is first seen low, the overload limit is OLP_START_MS ms ticks instead of OLP_RUN_MS.
- R5: After an overload trip, the gate stays off through `uv_on` edges until the fourth rising edge of `uv_off`. After that, the R1 rules apply.
- R6: `fb_overload` together with `vcc_low_sc` for SC_MS ms ticks turns the gate off with `fault_code` 3. A new `uv_on` rising edge re-enables.
- R7: `vcc_ovp` held for OVP_US µs ticks turns the gate off with `fault_code` 4. A new `uv_on` rising edge re-enables.
- R8: AUX_CYCLES consecutive `aux_valid` strobes with `aux_over` high turn the gate off with `fault_code` 5. A strobe with `aux_over` low restarts the count.
- R9: `over_temp` high while switching turns the gate off on the next edge with `fault_code` 6. The gate returns on the edge after the flag clears, with no `uv_on` needed.
- R10: `latch_low` accumulates µs ticks. The count clears only while `latch_high` is high and holds while both are low. At LATCH_US ticks the gate goes off with `fault_code` 7 from any state, and stays off through `uv_on` edges until `pdr`.
- R11: `rst` or `pdr` returns the block to its initial state: `gate_en` 0, `fault_code` 0, all counters and the brown-in and turn-on memories cleared.
- R12: Trips that occur on the same edge record the highest code. `uv_off` while switching turns the gate off without changing `fault_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| uv_on | input | 1 | Supply above turn-on threshold |
| uv_off | input | 1 | Supply below turn-off threshold |
| pdr | input | 1 | Power-down reset level |
| vcc_ovp | input | 1 | Supply overvoltage |
| fb_overload | input | 1 | Feedback above overload level |
| vcc_low_sc | input | 1 | Supply below short-circuit level |
| brown_out | input | 1 | Line below brown-out level |
| brown_in | input | 1 | Line above brown-in level |
| latch_low | input | 1 | External latch pin below trip level |
| latch_high | input | 1 | External latch pin above release level |
| over_temp | input | 1 | Chip over-temperature |
| aux_valid | input | 1 | Auxiliary overvoltage sample strobe, once per switching cycle |
| aux_over | input | 1 | Sampled auxiliary level above threshold |
| gate_en | output | 1 | Enable for both gate drivers |
| fault_code | output | 3 | Most recent fault, codes as in R2 to R10 |

## Verification
The in-line assertions check on every cycle four things. A power-down reset leaves the gate off with a zero code. Over-temperature, a latched state or a clean auxiliary sample each block what they must. No enable rises without a brown-in having been seen. A cleared debounce counter never reports a trip. The exact debounce lengths, the start-up overload limit, the four-crossing overload hold-off, the latch counter that holds between thresholds, and the priority of simultaneous trips all need multi-cycle stories. Only the bench's directed scenarios and its auxiliary sample table show these, by sampling the gate one cycle before and one cycle after each expected trip.

// File: rtl/psf_pkg.sv
package psf_pkg;
  typedef enum logic [2:0] {
    FC_NONE  = 3'd0,
    FC_BROWN = 3'd1,
    FC_OLP   = 3'd2,
    FC_SC    = 3'd3,
    FC_VOVP  = 3'd4,
    FC_AUX   = 3'd5,
    FC_OT    = 3'd6,
    FC_EXT   = 3'd7
  } fcode_e;

  typedef enum logic [2:0] {
    ST_WAIT  = 3'd0,
    ST_RUN   = 3'd1,
    ST_OLPH  = 3'd2,
    ST_OTH   = 3'd3,
    ST_LATCH = 3'd4
  } pstate_e;

  function automatic int psf_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/psf_dbnc.sv
module psf_dbnc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         cond,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         trip
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (cond && tick && (cnt < limit))
      cnt <= cnt + 1'b1;
  end

  assign trip = (cnt >= limit) && !clr;

  // R3: a cleared counter cannot report a trip on the next cycle
  a_r3_clear_blocks_trip: assert property (@(posedge clk) disable iff (rst)
    clr |=> !trip);
endmodule

// File: rtl/psf_aux_cnt.sv
module psf_aux_cnt #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic valid,
  input  logic over,
  output logic trip
);
  localparam int CW = $clog2(N + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (valid) begin
      if (!over)
        cnt <= '0;
      else if (cnt < CW'(N))
        cnt <= cnt + 1'b1;
    end
  end

  assign trip = (cnt == CW'(N));

  // R8: a clean sample leaves no pending trip
  a_r8_clean_sample_resets: assert property (@(posedge clk) disable iff (rst)
    (valid && !over && !clr) |=> !trip);
endmodule

// File: rtl/psf_ctrl.sv
module psf_ctrl
  import psf_pkg::*;
#(
  parameter int UV_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pdr,
  input  logic       uv_on,
  input  logic       uv_off,
  input  logic       brown_in,
  input  logic       fb_overload,
  input  logic       over_temp,
  input  logic       trip_bno,
  input  logic       trip_olp,
  input  logic       trip_sc,
  input  logic       trip_vovp,
  input  logic       trip_aux,
  input  logic       trip_ext,
  output logic       gate_en,
  output logic [2:0] fault_code,
  output logic       startup
);
  localparam int UW = $clog2(UV_CYCLES + 1);

  pstate_e       state;
  fcode_e        code;
  logic          uv_on_q, uv_off_q, armed, bi_seen;
  logic [UW-1:0] uv_cnt;
  logic          on_rise, off_rise;

  assign on_rise  = uv_on && !uv_on_q;
  assign off_rise = uv_off && !uv_off_q;

  always_ff @(posedge clk) begin
    if (rst || pdr) begin
      state    <= ST_WAIT;
      code     <= FC_NONE;
      gate_en  <= 1'b0;
      uv_on_q  <= 1'b0;
      uv_off_q <= 1'b0;
      armed    <= 1'b0;
      bi_seen  <= 1'b0;
      uv_cnt   <= '0;
      startup  <= 1'b0;
    end else begin
      uv_on_q  <= uv_on;
      uv_off_q <= uv_off;
      if (brown_in) bi_seen <= 1'b1;
      case (state)
        ST_WAIT: begin
          if (on_rise) armed <= 1'b1;
          if (armed && bi_seen && !over_temp) begin
            state   <= ST_RUN;
            gate_en <= 1'b1;
            startup <= 1'b1;
            armed   <= 1'b0;
          end
        end
        ST_RUN: begin
          if (!fb_overload) startup <= 1'b0;
          if (over_temp) begin
            state <= ST_OTH; gate_en <= 1'b0; code <= FC_OT;
          end else if (trip_aux) begin
            state <= ST_WAIT; gate_en <= 1'b0; code <= FC_AUX;
          end else if (trip_vovp) begin
            state <= ST_WAIT; gate_en <= 1'b0; code <= FC_VOVP;
          end else if (trip_sc) begin
            state <= ST_WAIT; gate_en <= 1'b0; code <= FC_SC;
          end else if (trip_olp) begin
            state <= ST_OLPH; gate_en <= 1'b0; code <= FC_OLP;
            uv_cnt <= '0;
          end else if (trip_bno) begin
            state <= ST_WAIT; gate_en <= 1'b0; code <= FC_BROWN;
            bi_seen <= 1'b0;
          end else if (uv_off) begin
            state <= ST_WAIT; gate_en <= 1'b0;
          end
        end
        ST_OLPH: begin
          if (off_rise) begin
            if (uv_cnt == UW'(UV_CYCLES - 1)) begin
              state  <= ST_WAIT;
              uv_cnt <= '0;
            end else begin
              uv_cnt <= uv_cnt + 1'b1;
            end
          end
        end
        ST_OTH: begin
          if (!over_temp) begin
            state   <= ST_RUN;
            gate_en <= 1'b1;
          end
        end
        default: state <= ST_LATCH;
      endcase
      if (trip_ext && state != ST_LATCH) begin
        state   <= ST_LATCH;
        gate_en <= 1'b0;
        code    <= FC_EXT;
      end
    end
  end

  assign fault_code = code;

  // R11: power-down reset returns to the initial outputs
  a_r11_pdr_clears: assert property (@(posedge clk) disable iff (rst)
    pdr |=> (!gate_en && fault_code == 3'd0));

  // R10: a latched state keeps the gate off until power-down reset
  a_r10_latch_holds: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LATCH && !pdr) |=> !gate_en);

  // R9: over-temperature never lets the gate be on the next cycle
  a_r9_ot_blocks: assert property (@(posedge clk) disable iff (rst)
    (over_temp && !pdr) |=> !gate_en);

  // R1: an enable edge needs a brown-in seen beforehand
  a_r1_needs_brown_in: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_en) |-> $past(bi_seen));

  // R5: during overload hold-off the gate stays off
  a_r5_olp_holds: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OLPH && !trip_ext) |=> !gate_en);
endmodule

// File: rtl/psu_fault_supervisor.sv
module psu_fault_supervisor
  import psf_pkg::*;
#(
  parameter int OLP_RUN_MS   = 64,
  parameter int OLP_START_MS = 74,
  parameter int SC_MS        = 16,
  parameter int BNO_MS       = 75,
  parameter int OVP_US       = 64,
  parameter int LATCH_US     = 500,
  parameter int AUX_CYCLES   = 4,
  parameter int UV_CYCLES    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_ms,
  input  logic       tick_us,
  input  logic       uv_on,
  input  logic       uv_off,
  input  logic       pdr,
  input  logic       vcc_ovp,
  input  logic       fb_overload,
  input  logic       vcc_low_sc,
  input  logic       brown_out,
  input  logic       brown_in,
  input  logic       latch_low,
  input  logic       latch_high,
  input  logic       over_temp,
  input  logic       aux_valid,
  input  logic       aux_over,
  output logic       gate_en,
  output logic [2:0] fault_code
);
  localparam int MS_MAX = psf_max(psf_max(OLP_RUN_MS, OLP_START_MS), psf_max(SC_MS, BNO_MS));
  localparam int US_MAX = psf_max(OVP_US, LATCH_US);
  localparam int MS_W   = $clog2(MS_MAX + 1);
  localparam int US_W   = $clog2(US_MAX + 1);

  logic            trip_bno, trip_olp, trip_sc, trip_vovp, trip_aux, trip_ext;
  logic            startup;
  logic [MS_W-1:0] olp_limit;

  assign olp_limit = startup ? MS_W'(OLP_START_MS) : MS_W'(OLP_RUN_MS);

  psf_dbnc #(.W(MS_W)) u_olp (
    .clk(clk), .rst(rst), .clr(pdr || !gate_en || !fb_overload),
    .cond(fb_overload), .tick(tick_ms), .limit(olp_limit), .trip(trip_olp));

  psf_dbnc #(.W(MS_W)) u_sc (
    .clk(clk), .rst(rst), .clr(pdr || !gate_en || !(fb_overload && vcc_low_sc)),
    .cond(fb_overload && vcc_low_sc), .tick(tick_ms), .limit(MS_W'(SC_MS)),
    .trip(trip_sc));

  psf_dbnc #(.W(MS_W)) u_bno (
    .clk(clk), .rst(rst), .clr(pdr || !brown_out),
    .cond(brown_out), .tick(tick_ms), .limit(MS_W'(BNO_MS)), .trip(trip_bno));

  psf_dbnc #(.W(US_W)) u_vovp (
    .clk(clk), .rst(rst), .clr(pdr || !vcc_ovp),
    .cond(vcc_ovp), .tick(tick_us), .limit(US_W'(OVP_US)), .trip(trip_vovp));

  // external latch: only the upper comparator clears the count
  psf_dbnc #(.W(US_W)) u_ext (
    .clk(clk), .rst(rst), .clr(pdr || latch_high),
    .cond(latch_low), .tick(tick_us), .limit(US_W'(LATCH_US)), .trip(trip_ext));

  psf_aux_cnt #(.N(AUX_CYCLES)) u_aux (
    .clk(clk), .rst(rst), .clr(pdr || !gate_en),
    .valid(aux_valid), .over(aux_over), .trip(trip_aux));

  psf_ctrl #(.UV_CYCLES(UV_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .pdr(pdr), .uv_on(uv_on), .uv_off(uv_off),
    .brown_in(brown_in), .fb_overload(fb_overload), .over_temp(over_temp),
    .trip_bno(trip_bno), .trip_olp(trip_olp), .trip_sc(trip_sc),
    .trip_vovp(trip_vovp), .trip_aux(trip_aux), .trip_ext(trip_ext),
    .gate_en(gate_en), .fault_code(fault_code), .startup(startup));
endmodule

// File: tb/sim_psu_fault_supervisor.sv
module sim_psu_fault_supervisor;
  logic clk = 1'b0;
  logic rst, tick_ms, tick_us, uv_on, uv_off, pdr, vcc_ovp, fb_overload;
  logic vcc_low_sc, brown_out, brown_in, latch_low, latch_high, over_temp;
  logic aux_valid, aux_over, gate_en;
  logic [2:0] fault_code;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  psu_fault_supervisor u0 (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .tick_us(tick_us),
    .uv_on(uv_on), .uv_off(uv_off), .pdr(pdr), .vcc_ovp(vcc_ovp),
    .fb_overload(fb_overload), .vcc_low_sc(vcc_low_sc), .brown_out(brown_out),
    .brown_in(brown_in), .latch_low(latch_low), .latch_high(latch_high),
    .over_temp(over_temp), .aux_valid(aux_valid), .aux_over(aux_over),
    .gate_en(gate_en), .fault_code(fault_code));

  // aux vectors: {samples LSB first [12:5], count [4:1], expected gate [0]}
  localparam logic [12:0] AUXV [4] = '{
    {8'b0000_1111, 4'd4, 1'b0},
    {8'b0111_0111, 4'd7, 1'b1},
    {8'b0001_1110, 4'd5, 1'b0},
    {8'b0000_0111, 4'd3, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    tick_ms = 1; tick_us = 1; uv_on = 0; uv_off = 0; pdr = 0; vcc_ovp = 0;
    fb_overload = 0; vcc_low_sc = 0; brown_out = 0; brown_in = 0;
    latch_low = 0; latch_high = 1; over_temp = 0; aux_valid = 0; aux_over = 0;
    rst = 1; settle(2); rst = 0; settle(1);
  endtask

  task automatic uv_pulse();
    uv_on = 1; settle(1); uv_on = 0; settle(1);
  endtask

  task automatic power_up();
    brown_in = 1; uv_pulse();
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    do_reset();
    chk("R11 reset gate", gate_en, 0);
    chk("R11 reset code", fault_code, 0);

    // R1 no brown-in, then normal start
    uv_pulse(); settle(2);
    chk("R1 no brown-in gate", gate_en, 0);
    do_reset(); power_up();
    chk("R1 start gate", gate_en, 1);

    // R4 start-up overload limit
    do_reset(); fb_overload = 1; power_up();
    settle(74); chk("R4 before start-up limit", gate_en, 1);
    settle(1);  chk("R4 after start-up limit", gate_en, 0);
    chk("R4 code", fault_code, 2);

    // R3 run overload, glitch restart, R5 hold-off
    do_reset(); power_up(); settle(3);
    fb_overload = 1; settle(40); fb_overload = 0; settle(1);
    chk("R3 interrupted overload", gate_en, 1);
    fb_overload = 1; settle(64); chk("R3 before limit", gate_en, 1);
    settle(1); chk("R3 after limit", gate_en, 0);
    chk("R3 code", fault_code, 2);
    fb_overload = 0;
    for (int i = 0; i < 3; i++) begin uv_off = 1; settle(1); uv_off = 0; settle(1); end
    uv_pulse(); settle(1);
    chk("R5 held after three uv_off", gate_en, 0);
    chk("R5 code readable", fault_code, 2);
    uv_off = 1; settle(1); uv_off = 0; settle(1);
    uv_pulse();
    chk("R5 released after fourth uv_off", gate_en, 1);

    // R6 short circuit
    do_reset(); power_up(); settle(3);
    vcc_low_sc = 1; fb_overload = 1; settle(16);
    chk("R6 before limit", gate_en, 1);
    settle(1); chk("R6 after limit", gate_en, 0);
    chk("R6 code", fault_code, 3);
    vcc_low_sc = 0; fb_overload = 0; uv_pulse();
    chk("R6 recovery", gate_en, 1);

    // R7 supply overvoltage
    do_reset(); power_up(); settle(3);
    vcc_ovp = 1; settle(64); chk("R7 before limit", gate_en, 1);
    settle(1); chk("R7 after limit", gate_en, 0);
    chk("R7 code", fault_code, 4);
    vcc_ovp = 0; uv_pulse();
    chk("R7 recovery", gate_en, 1);

    // R8 auxiliary sample table
    for (int v = 0; v < 4; v++) begin
      do_reset(); power_up(); settle(2);
      for (int k = 0; k < int'(AUXV[v][4:1]); k++) begin
        aux_valid = 1; aux_over = AUXV[v][5 + k]; settle(1);
        aux_valid = 0; settle(1);
      end
      settle(1);
      chk("R8 aux vector gate", gate_en, int'(AUXV[v][0]));
      if (!AUXV[v][0]) chk("R8 aux code", fault_code, 5);
    end

    // R9 over-temperature
    do_reset(); power_up(); settle(2);
    over_temp = 1; settle(1);
    chk("R9 off", gate_en, 0);
    chk("R9 code", fault_code, 6);
    over_temp = 0; settle(1);
    chk("R9 auto return", gate_en, 1);

    // R2 brown-out
    do_reset(); power_up(); brown_in = 0; settle(2);
    brown_out = 1; settle(75); chk("R2 before limit", gate_en, 1);
    settle(1); chk("R2 after limit", gate_en, 0);
    chk("R2 code", fault_code, 1);
    brown_out = 0; uv_pulse(); settle(1);
    chk("R2 needs brown-in again", gate_en, 0);
    brown_in = 1; settle(1); brown_in = 0; uv_pulse();
    chk("R2 recovery", gate_en, 1);

    // R10 external latch with hold between thresholds
    do_reset(); power_up(); settle(2);
    latch_high = 0; latch_low = 1; settle(300);
    latch_low = 0; settle(50);
    latch_low = 1; settle(200);
    chk("R10 before limit", gate_en, 1);
    settle(1); chk("R10 after limit", gate_en, 0);
    chk("R10 code", fault_code, 7);
    latch_low = 0; latch_high = 1; uv_pulse(); settle(1);
    chk("R10 stays latched", gate_en, 0);
    pdr = 1; settle(1); pdr = 0; settle(1);
    chk("R11 pdr gate", gate_en, 0);
    chk("R11 pdr code", fault_code, 0);
    power_up();
    chk("R11 restart after pdr", gate_en, 1);
    do_reset(); power_up(); settle(2);
    latch_high = 0; latch_low = 1; settle(400);
    latch_low = 0; latch_high = 1; settle(1);
    latch_high = 0; latch_low = 1; settle(400);
    chk("R10 upper threshold clears count", gate_en, 1);

    // R12 priority and uv_off while switching
    do_reset(); power_up(); settle(3);
    vcc_ovp = 1; settle(64); over_temp = 1; settle(1);
    chk("R12 priority code", fault_code, 6);
    do_reset(); power_up(); settle(2);
    uv_off = 1; settle(1); uv_off = 0;
    chk("R12 uv_off gate", gate_en, 0);
    chk("R12 uv_off code", fault_code, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule